// File: doc/BRIEF.md
# Sequential bfloat16 Multiplier

This block multiplies two bfloat16 numbers for a datapath that has no hardware multiplier. A one-cycle `start` strobe latches both operands. The block splits each operand into sign, biased exponent and an 8-bit significand, with the implicit leading one restored above the seven stored fraction bits. It then builds the 16-bit significand product over eight clocks, adding a shifted copy of the multiplicand once for each multiplier bit. A final clock normalizes the product, forms the biased result exponent and packs the result word.

The result is truncated. An exponent that falls to zero or below is clamped to a zero field, and a sum too large for eight bits wraps. Infinity, NaN and subnormal encodings get no special treatment, so every operand is decoded as a normal number. While a product is being formed, `busy` is high and further start strobes are ignored. `done` marks the one cycle in which `result` holds the new product.

Top module: `bf16_seq_mul`

## Requirements
- R1: An operand word is decoded as sign in bit 15, biased exponent in bits 14:7 and fraction in bits 6:0. The significand is the fraction with a 1 placed above it at bit 7, and this applies even when the exponent field is zero.
- R2: Bit 15 of the result is the XOR of the two operand sign bits.
- R3: The significand product is the exact 16-bit product of the two 8-bit significands. It is formed by shift-and-add, one multiplier bit per clock, over eight clocks.
- R4: When bit 15 of the product is 1, the product is shifted right by one place and the normalization shift is 1; otherwise the shift is 0.
- R5: The result exponent is exp_a + exp_b - 127 + shift, evaluated as a signed value.
- R6: When the signed result exponent is zero or negative, bits 14:7 of the result are 0. The fraction field is still taken from the normalized product.
- R7: Result bits 6:0 are bits 13:7 of the normalized product, truncated with no rounding.
- R8: A result exponent above 255 is not saturated; bits 14:7 hold its low eight bits.
- R9: After a start strobe is accepted at a clock edge, `done` is high for exactly one cycle, nine edges later, with `result` valid in that cycle. `busy` is high from the accepting edge until that cycle and is low while `done` is high.
- R10: Operands are captured on the accepting edge. A start strobe while `busy` is high changes neither the result nor the timing, and it produces no second `done`.
- R11: After a synchronous reset, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; accepted only while not busy |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | 16 | Packed bfloat16 product |

## Verification
The bound checker watches the handshake on every cycle. It checks that an accepted start raises `busy`, that `done` is a single-cycle pulse exactly nine edges after acceptance with `busy` low, that the sign is the XOR of the captured operand signs, and that small exponent sums give a zero exponent field. Other parts of the arithmetic can only be shown by the bench's sweeps against an arithmetic model. These are the exact product, the normalization shift, the truncated fraction, the exponent wrap above 255, and the fact that an operand change during a busy phase does not leak into the result.

// File: rtl/bf16_mul_pkg.sv
package bf16_mul_pkg;

  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 7;
  localparam int DEF_BIAS   = 127;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_PACK = 2'd2
  } mul_state_e;

endpackage

// File: rtl/bf16_unpack.sv
module bf16_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  assign sign  = word[WORD_W-1];
  assign exp_f = word[WORD_W-2 -: EXP_W];
  // hidden one restored regardless of exponent value
  assign sig   = {1'b1, word[FRAC_W-1:0]};
endmodule

// File: rtl/bf16_shadd_core.sv
module bf16_shadd_core #(
  parameter int SIG_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [SIG_W-1:0]   mcand_in,
  input  logic [SIG_W-1:0]   mplier_in,
  output logic [2*SIG_W-1:0] prod,
  output logic               last
);
  localparam int PROD_W = 2 * SIG_W;
  localparam int CNT_W  = (SIG_W > 1) ? $clog2(SIG_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SIG_W - 1);

  logic [PROD_W-1:0] mcand_sh;
  logic [SIG_W-1:0]  mplier_sh;
  logic [PROD_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_sh  <= '0;
      mplier_sh <= '0;
      acc       <= '0;
      cnt       <= '0;
    end else if (load) begin
      mcand_sh  <= {{(PROD_W-SIG_W){1'b0}}, mcand_in};
      mplier_sh <= mplier_in;
      acc       <= '0;
      cnt       <= '0;
    end else if (step) begin
      if (mplier_sh[0]) acc <= acc + mcand_sh;
      mcand_sh  <= mcand_sh << 1;
      mplier_sh <= mplier_sh >> 1;
      cnt       <= cnt + 1'b1;
    end
  end

  assign prod = acc;
  assign last = step && (cnt == CNT_LAST);
endmodule

// File: rtl/bf16_norm_pack.sv
module bf16_norm_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7,
  parameter int BIAS   = 127
) (
  input  logic                      sign,
  input  logic [EXP_W-1:0]          exp_a,
  input  logic [EXP_W-1:0]          exp_b,
  input  logic [2*(FRAC_W+1)-1:0]   prod,
  output logic [EXP_W+FRAC_W:0]     word
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ESUM_W = EXP_W + 2;

  logic                     shift;
  logic [PROD_W-1:0]        norm;
  logic signed [ESUM_W-1:0] esum;
  logic [EXP_W-1:0]         exp_fld;

  assign shift = prod[PROD_W-1];
  assign norm  = shift ? (prod >> 1) : prod;

  assign esum = $signed(ESUM_W'(exp_a) + ESUM_W'(exp_b) + ESUM_W'(shift)
                        - ESUM_W'(BIAS));

  // non-positive exponent clamps to zero; large values wrap by truncation
  assign exp_fld = (esum[ESUM_W-1] || (esum == '0)) ? '0 : esum[EXP_W-1:0];

  assign word = {sign, exp_fld, norm[PROD_W-3 -: FRAC_W]};
endmodule

// File: rtl/bf16_seq_mul.sv
module bf16_seq_mul
  import bf16_mul_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int BIAS   = DEF_BIAS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic                    busy,
  output logic                    done,
  output logic [EXP_W+FRAC_W:0]   result
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [WORD_W-1:0] in_word [2];
  logic              in_sign [2];
  logic [EXP_W-1:0]  in_exp  [2];
  logic [SIG_W-1:0]  in_sig  [2];

  assign in_word[0] = op_a;
  assign in_word[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_unpack
    bf16_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_unpack (
      .word  (in_word[k]),
      .sign  (in_sign[k]),
      .exp_f (in_exp[k]),
      .sig   (in_sig[k])
    );
  end

  mul_state_e        state;
  logic              busy_q, done_q;
  logic [WORD_W-1:0] result_q;
  logic              sign_q;
  logic [EXP_W-1:0]  exp_a_q, exp_b_q;
  logic              accept;
  logic [PROD_W-1:0] prod;
  logic              last;
  logic [WORD_W-1:0] packed_w;

  assign accept = start && !busy_q;

  bf16_shadd_core #(.SIG_W(SIG_W)) i_core (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (state == ST_MUL),
    .mcand_in  (in_sig[0]),
    .mplier_in (in_sig[1]),
    .prod      (prod),
    .last      (last)
  );

  bf16_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) i_pack (
    .sign  (sign_q),
    .exp_a (exp_a_q),
    .exp_b (exp_b_q),
    .prod  (prod),
    .word  (packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
      sign_q   <= 1'b0;
      exp_a_q  <= '0;
      exp_b_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            sign_q  <= in_sign[0] ^ in_sign[1];
            exp_a_q <= in_exp[0];
            exp_b_q <= in_exp[1];
            busy_q  <= 1'b1;
            state   <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (last) state <= ST_PACK;
        end
        ST_PACK: begin
          result_q <= packed_w;
          done_q   <= 1'b1;
          busy_q   <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/bf16_seq_mul_chk.sv
module bf16_seq_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7,
  parameter int BIAS   = 127
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  busy,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] result
);
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int LAT     = FRAC_W + 2;
  localparam int LCNT_W  = $clog2(LAT + 2);

  logic [WORD_W-1:0] cap_a, cap_b;
  logic [LCNT_W-1:0] lat_cnt;
  logic [EXP_W:0]    cap_esum;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a   <= '0;
      cap_b   <= '0;
      lat_cnt <= '0;
    end else if (start && !busy) begin
      cap_a   <= op_a;
      cap_b   <= op_b;
      lat_cnt <= '0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assign cap_esum = (EXP_W+1)'(cap_a[WORD_W-2 -: EXP_W]) + (EXP_W+1)'(cap_b[WORD_W-2 -: EXP_W]);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R9
  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LCNT_W'(LAT))); // R10
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    done |-> (result[WORD_W-1] == (cap_a[WORD_W-1] ^ cap_b[WORD_W-1]))); // R2
  AST_UNDERFLOW_ZERO_EXP: assert property (@(posedge clk) disable iff (rst)
    (done && (cap_esum < (EXP_W+1)'(BIAS))) |-> (result[WORD_W-2 -: EXP_W] == '0)); // R6
endmodule

bind bf16_seq_mul bf16_seq_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op_a   (op_a),
  .op_b   (op_b),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/test_bf16_seq_mul.sv
module test_bf16_seq_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [15:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bf16_seq_mul i_bf16_seq_mul (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9: run exceeded %0d cycles (expected completion earlier)", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // arithmetic reference from the requirements
  function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                output logic [15:0] res, output string tag);
    int ma, mb, p, sh, n, e;
    ma = 128 + int'(a[6:0]);          // R1 hidden one
    mb = 128 + int'(b[6:0]);
    p  = ma * mb;                     // R3 exact product
    sh = (p >= 32768) ? 1 : 0;        // R4
    n  = p >> sh;
    e  = int'(a[14:7]) + int'(b[14:7]) - 127 + sh;  // R5
    if (e <= 0) begin e = 0; tag = "R6 underflow"; end   // R6
    else if (e > 255) tag = "R8 wrap";                    // R8
    else tag = "R5 R7 normal";
    res = {a[15] ^ b[15], 8'(e), 7'((n >> 7) & 127)};    // R2 R7
  endfunction

  task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                        output logic [15:0] res, output int lat, output bit busy_ok);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    busy_ok = busy;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
      if (!done) busy_ok &= busy;
      else busy_ok &= !busy;
    end
    res = result;
  endtask

  initial begin
    logic [15:0] r, e;
    string tag;
    int lat;
    bit bok;

    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == 16'h0, "R11 reset state",
          {14'b0, busy, done} | result, 16'h0);
    rst = 1'b0;

    // directed corners
    run_op(16'h3F80, 16'h3F80, r, lat, bok);
    check(r == 16'h3F80, "R1 one times one", r, 16'h3F80);
    check(lat == 9, "R9 latency", 16'(lat), 16'd9);
    check(bok, "R9 busy window", {15'b0, bok}, 16'h1);
    run_op(16'hBFFF, 16'h3FFF, r, lat, bok);
    model(16'hBFFF, 16'h3FFF, e, tag);
    check(r == e, "R4 max significand product, shift 1", r, e);
    run_op(16'h0000, 16'h3F80, r, lat, bok);
    check(r == 16'h0000, "R6 zero exponent field input", r, 16'h0000);
    run_op(16'h7F00, 16'h7F00, r, lat, bok);
    check(r == 16'h3E80, "R8 exponent wrap", r, 16'h3E80);
    run_op(16'h3FC0, 16'hC040, r, lat, bok);
    model(16'h3FC0, 16'hC040, e, tag);
    check(r == e, "R2 R5 mixed signs", r, e);

    // R10: start while busy is ignored
    @(negedge clk);
    op_a = 16'h4040; op_b = 16'h4000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = 16'hC2AA; op_b = 16'h1234;
    lat = 0;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
      if (lat == 3) start = 1'b1;
      if (lat == 4) begin start = 1'b0; op_a = 16'h0; op_b = 16'h0; end
    end
    model(16'h4040, 16'h4000, e, tag);
    check(result == e, "R10 operands held across busy start", result, e);
    check(lat == 9, "R10 timing unchanged", 16'(lat), 16'd9);
    begin
      bit extra = 1'b0;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        extra |= done | busy;
      end
      check(!extra, "R10 no second done", {15'b0, extra}, 16'h0);
    end

    // R3 R4 R7: significand sweep at unit exponents, varied signs
    for (int fa = 0; fa < 128; fa++) begin
      for (int fb = 0; fb < 128; fb += 2) begin
        logic [15:0] a, b;
        a = {1'(fa & 1), 8'd127, 7'(fa)};
        b = {1'((fa >> 1) ^ fb), 8'd127, 7'(fb | (fa >> 6))};
        run_op(a, b, r, lat, bok);
        model(a, b, e, tag);
        check(r == e, "R3 R4 R7 significand sweep", r, e);
      end
    end

    // R5 R6 R8: exponent sweep with latency and busy checks
    for (int ea = 0; ea < 256; ea += 5) begin
      for (int eb = 0; eb < 256; eb += 17) begin
        logic [15:0] a, b;
        a = {1'(ea >> 2), 8'(ea), 7'((ea * 37 + eb * 11) & 127)};
        b = {1'(eb), 8'(eb), 7'((ea * 5 + eb * 29 + 3) & 127)};
        run_op(a, b, r, lat, bok);
        model(a, b, e, tag);
        check(r == e, tag, r, e);
        check(lat == 9 && bok, "R9 done timing and busy", 16'(lat), 16'd9);
      end
    end

    summary();
    $finish;
  end
endmodule